// File: doc/BRIEF.md
# Timed Transmit Burst Sequencer

This block runs the power-up and transmit schedule of a radio front end against a quarter-bit timebase. It holds a free-running quarter-bit counter that advances once every `QB_DIV` clocks and wraps after `QB_WRAP`. A step machine walks a fixed schedule. It raises parallel control pins one at a time and hands register-write requests to an external serial writer. Between actions it waits exact quarter-bit intervals, and at the end it opens an uplink burst window between two absolute counter values.

A host drives `start` with the channel word on `chan_word`. The block captures that word, sequences the synthesizer warm-up, the channel load and the transmit configuration, and enables the power amplifier and the low-band transmit path. It then holds `burst_en` high for the programmed window and pulses `done`. The serial writer and the computation of the channel word are outside the block. Every action of the step machine lands on a quarter-bit tick, so waits are whole quarter bits. Elapsed time is measured in a way that stays correct when a wait crosses the counter wrap.

Top module: `txburst_seq`

## Requirements
- R1: While reset is held and directly after it, `rf_pins`, `wr_req`, `burst_en`, `done` and `qb_count` are all zero.
- R2: `qb_count` advances by exactly one every `QB_DIV` clocks and goes from `QB_WRAP` back to 0.
- R3: After `start` in idle, the VCO-enable pin (bit `VCO_BIT`, default 0) is set at the next quarter-bit tick. Exactly 21 quarter bits later, a write to address 2 carries `WARM_WORD`.
- R4: The writes come in the order address 2 (`WARM_WORD`), address 1 (the channel word), address 2 (`TXMODE_WORD`), address 11 (`TXSET_WORD`). They are spaced 169 (5 write + 164 warm-up), 5 and 5 quarter bits apart.
- R5: 127 quarter bits (5 write + 122 settle) after the address 11 write, the PA-enable pin (bit `PA_BIT`, default 1) is added. 12 quarter bits later the low-band transmit pin (bit `LB_BIT`, default 2) is added. Pins only accumulate and are cleared only in the cycle `done` is high.
- R6: A wait that crosses the counter wrap lasts the same number of quarter bits as one that does not.
- R7: No write request is issued while `wr_busy` is high. A stalled write fires at the first tick after `wr_busy` falls, and the next wait counts from that issue.
- R8: `burst_en` rises in the cycle `qb_count` becomes `WIN_ON` (default 0x7A0). It falls in the cycle `qb_count` becomes `WIN_OFF` (default 0x2700). `done` is high for that one cycle only.
- R9: `start` pulses during a running sequence change nothing, and no later sequence results from them. Changes on `chan_word` after the accepting `start` have no effect on the address 1 write.
- R10: `wr_req` is high for single cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| chan_word | input | DATA_W | Channel word, captured at start |
| wr_busy | input | 1 | Serial writer cannot take a request |
| rf_pins | output | PIN_W | Parallel front-end control pins |
| wr_req | output | 1 | Single-cycle register write request |
| wr_addr | output | 4 | Register address of the request |
| wr_data | output | DATA_W | Register data of the request |
| burst_en | output | 1 | Uplink burst window enable |
| done | output | 1 | One-cycle pulse when the window closes |
| qb_count | output | CNT_W | Quarter-bit timebase count |

## Verification
The first sequence starts close to count zero with an idle writer. It fixes the nominal spacing of every pin change and write, together with the window edges. The second starts 40 quarter bits before the wrap, so the 169 quarter-bit warm-up straddles it. During that run the bench also pulses `start` and changes `chan_word`, which separates a wrap-aware elapsed measure from a naive subtraction and shows that the captured word and the running schedule are unaffected. The third holds the writer busy well past a due write, which tells apart issue-time wait tracking from schedule-time tracking and exposes any request made while busy.

// File: rtl/txb_pkg.sv
package txb_pkg;

   localparam int ADDR_W = 4;
   localparam int WAIT_W = 8;
   localparam int NSTEP  = 7;

   // Quarter-bit intervals of the schedule
   localparam int QB_VCO_SETTLE = 21;
   localparam int QB_WR         = 5;
   localparam int QB_WARM       = 164;
   localparam int QB_TX_SETTLE  = 122;
   localparam int QB_PA_SETTLE  = 12;

   typedef enum logic [2:0] {
      PH_IDLE, PH_ARM, PH_WAIT, PH_STALL, PH_WINARM, PH_WINOPEN
   } phase_t;

   typedef enum logic [1:0] {
      DS_WARM, DS_CHAN, DS_TXMODE, DS_TXSET
   } dsel_t;

   typedef struct packed {
      logic              is_wr;
      logic [ADDR_W-1:0] addr;
      dsel_t             dsel;
      logic [2:0]        pinsel;   // {lb, pa, vco}
      logic [WAIT_W-1:0] wait_qb;
   } step_t;

   function automatic step_t step_of(input logic [2:0] idx);
      step_t s;
      s = '{is_wr: 1'b0, addr: '0, dsel: DS_WARM, pinsel: 3'b000, wait_qb: '0};
      case (idx)
         3'd0: begin s.pinsel = 3'b001; s.wait_qb = WAIT_W'(QB_VCO_SETTLE); end
         3'd1: begin s.is_wr = 1'b1; s.addr = 4'd2;  s.dsel = DS_WARM;
                     s.wait_qb = WAIT_W'(QB_WR + QB_WARM); end
         3'd2: begin s.is_wr = 1'b1; s.addr = 4'd1;  s.dsel = DS_CHAN;
                     s.wait_qb = WAIT_W'(QB_WR); end
         3'd3: begin s.is_wr = 1'b1; s.addr = 4'd2;  s.dsel = DS_TXMODE;
                     s.wait_qb = WAIT_W'(QB_WR); end
         3'd4: begin s.is_wr = 1'b1; s.addr = 4'd11; s.dsel = DS_TXSET;
                     s.wait_qb = WAIT_W'(QB_WR + QB_TX_SETTLE); end
         3'd5: begin s.pinsel = 3'b011; s.wait_qb = WAIT_W'(QB_PA_SETTLE); end
         default: begin s.pinsel = 3'b111; s.wait_qb = '0; end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/txb_timebase.sv
module txb_timebase #(
   parameter int CNT_W   = 14,
   parameter int QB_DIV  = 2,
   parameter int QB_WRAP = 10239
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(QB_WRAP);

   generate
      if (QB_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PRE_W = $clog2(QB_DIV);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(QB_DIV - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             pre_q <= '0;
            else if (pre_q == PRE_LAST) pre_q <= '0;
            else                    pre_q <= pre_q + PRE_W'(1);
         end
         assign tick = (pre_q == PRE_LAST);
      end
   endgenerate

   always_comb begin
      cnt_nxt = cnt_q;
      if (tick) cnt_nxt = (cnt_q == WRAP_V) ? '0 : cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/txb_elapsed.sv
module txb_elapsed #(
   parameter int CNT_W   = 14,
   parameter int QB_WRAP = 10239
) (
   input  logic [CNT_W-1:0] cur,
   input  logic [CNT_W-1:0] last,
   output logic [CNT_W-1:0] elapsed
);
   localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(QB_WRAP);

   always_comb begin
      if (cur >= last) elapsed = cur - last;
      else             elapsed = (WRAP_V - last) + cur + CNT_W'(1);
   end
endmodule

// File: rtl/txb_steps.sv
module txb_steps
   import txb_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter int DATA_W  = 24,
   parameter int PIN_W   = 4,
   parameter int VCO_BIT = 0,
   parameter int PA_BIT  = 1,
   parameter int LB_BIT  = 2,
   parameter logic [DATA_W-1:0] WARM_WORD   = 24'h3E_1C42,
   parameter logic [DATA_W-1:0] TXMODE_WORD = 24'h00_0310,
   parameter logic [DATA_W-1:0] TXSET_WORD  = 24'h1A_0045,
   parameter int WIN_ON  = 'h7A0,
   parameter int WIN_OFF = 'h2700
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [CNT_W-1:0]  cnt_nxt,
   input  logic [CNT_W-1:0]  elapsed,
   input  logic              start,
   input  logic [DATA_W-1:0] chan_word,
   input  logic              wr_busy,
   output logic [CNT_W-1:0]  last_cnt,
   output logic [PIN_W-1:0]  pins,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              burst_en,
   output logic              done
);
   localparam logic [2:0] LAST_IDX = 3'(NSTEP - 1);
   localparam logic [CNT_W-1:0] ON_V  = CNT_W'(WIN_ON);
   localparam logic [CNT_W-1:0] OFF_V = CNT_W'(WIN_OFF);

   phase_t            phase_q;
   logic [2:0]        idx_q;
   logic [WAIT_W-1:0] wait_q;
   logic [DATA_W-1:0] chan_q;
   step_t             st;
   logic              act_now;
   logic [PIN_W-1:0]  pin_set;
   logic [DATA_W-1:0] sel_data;

   assign st = step_of(idx_q);

   // Map schedule pin selections onto the configured bus positions
   generate
      for (genvar i = 0; i < PIN_W; i++) begin : g_pin
         assign pin_set[i] = ((i == VCO_BIT) && st.pinsel[0]) ||
                             ((i == PA_BIT)  && st.pinsel[1]) ||
                             ((i == LB_BIT)  && st.pinsel[2]);
      end
   endgenerate

   always_comb begin
      case (st.dsel)
         DS_WARM:   sel_data = WARM_WORD;
         DS_CHAN:   sel_data = chan_q;
         DS_TXMODE: sel_data = TXMODE_WORD;
         default:   sel_data = TXSET_WORD;
      endcase
   end

   assign act_now = tick && ((phase_q == PH_ARM) || (phase_q == PH_STALL) ||
                    ((phase_q == PH_WAIT) && (elapsed >= CNT_W'(wait_q))));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         idx_q    <= '0;
         wait_q   <= '0;
         chan_q   <= '0;
         last_cnt <= '0;
         pins     <= '0;
         wr_req   <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         burst_en <= 1'b0;
         done     <= 1'b0;
      end else begin
         wr_req <= 1'b0;
         done   <= 1'b0;
         case (phase_q)
            PH_IDLE: if (start) begin
               chan_q  <= chan_word;
               idx_q   <= '0;
               phase_q <= PH_ARM;
            end
            PH_ARM, PH_WAIT, PH_STALL: if (act_now) begin
               if (st.is_wr && wr_busy) begin
                  phase_q <= PH_STALL;
               end else begin
                  if (st.is_wr) begin
                     wr_req  <= 1'b1;
                     wr_addr <= st.addr;
                     wr_data <= sel_data;
                  end else begin
                     pins <= pin_set;
                  end
                  last_cnt <= cnt_q;
                  wait_q   <= st.wait_qb;
                  if (idx_q == LAST_IDX) begin
                     phase_q <= PH_WINARM;
                  end else begin
                     idx_q   <= idx_q + 3'd1;
                     phase_q <= PH_WAIT;
                  end
               end
            end
            PH_WINARM: if (tick && cnt_nxt == ON_V) begin
               burst_en <= 1'b1;
               phase_q  <= PH_WINOPEN;
            end
            PH_WINOPEN: if (tick && cnt_nxt == OFF_V) begin
               burst_en <= 1'b0;
               done     <= 1'b1;
               pins     <= '0;
               phase_q  <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txburst_seq.sv
module txburst_seq
   import txb_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter int QB_DIV  = 2,
   parameter int QB_WRAP = 10239,
   parameter int DATA_W  = 24,
   parameter int PIN_W   = 4,
   parameter int VCO_BIT = 0,
   parameter int PA_BIT  = 1,
   parameter int LB_BIT  = 2,
   parameter logic [DATA_W-1:0] WARM_WORD   = 24'h3E_1C42,
   parameter logic [DATA_W-1:0] TXMODE_WORD = 24'h00_0310,
   parameter logic [DATA_W-1:0] TXSET_WORD  = 24'h1A_0045,
   parameter int WIN_ON  = 'h7A0,
   parameter int WIN_OFF = 'h2700
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] chan_word,
   input  logic              wr_busy,
   output logic [PIN_W-1:0]  rf_pins,
   output logic              wr_req,
   output logic [3:0]        wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              burst_en,
   output logic              done,
   output logic [CNT_W-1:0]  qb_count
);
   if (QB_DIV < 1) begin : g_bad_div
      $error("QB_DIV must be at least 1");
   end
   if (QB_WRAP >= (1 << CNT_W)) begin : g_bad_wrap
      $error("QB_WRAP does not fit in CNT_W bits");
   end
   if (!(WIN_ON < WIN_OFF && WIN_OFF <= QB_WRAP)) begin : g_bad_win
      $error("window counts must satisfy WIN_ON < WIN_OFF <= QB_WRAP");
   end
   if (QB_WRAP < 256) begin : g_bad_short
      $error("QB_WRAP must exceed the longest schedule wait");
   end
   if (PIN_W < 3 || VCO_BIT >= PIN_W || PA_BIT >= PIN_W || LB_BIT >= PIN_W ||
       VCO_BIT == PA_BIT || VCO_BIT == LB_BIT || PA_BIT == LB_BIT) begin : g_bad_pins
      $error("pin positions must be distinct and inside PIN_W");
   end

   logic             tick;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, last_cnt, elapsed;

   txb_timebase #(.CNT_W(CNT_W), .QB_DIV(QB_DIV), .QB_WRAP(QB_WRAP)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
   );

   txb_elapsed #(.CNT_W(CNT_W), .QB_WRAP(QB_WRAP)) u_el (
      .cur(cnt_q), .last(last_cnt), .elapsed(elapsed)
   );

   txb_steps #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .PIN_W(PIN_W),
      .VCO_BIT(VCO_BIT), .PA_BIT(PA_BIT), .LB_BIT(LB_BIT),
      .WARM_WORD(WARM_WORD), .TXMODE_WORD(TXMODE_WORD), .TXSET_WORD(TXSET_WORD),
      .WIN_ON(WIN_ON), .WIN_OFF(WIN_OFF)
   ) u_st (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
      .elapsed(elapsed), .start(start), .chan_word(chan_word), .wr_busy(wr_busy),
      .last_cnt(last_cnt), .pins(rf_pins), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .burst_en(burst_en), .done(done)
   );

   assign qb_count = cnt_q;
endmodule

// File: rtl/txburst_seq_chk.sv
module txburst_seq_chk #(
   parameter int CNT_W   = 14,
   parameter int PIN_W   = 4,
   parameter int QB_WRAP = 10239,
   parameter int WIN_ON  = 'h7A0,
   parameter int WIN_OFF = 'h2700
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PIN_W-1:0] rf_pins,
   input logic             wr_req,
   input logic             wr_busy,
   input logic             burst_en,
   input logic             done,
   input logic [CNT_W-1:0] qb_count
);
   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> !wr_req);                                             // R10
   AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !$past(wr_busy));                                     // R7
   AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_en |-> (qb_count >= CNT_W'(WIN_ON) && qb_count < CNT_W'(WIN_OFF))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                 // R8
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (qb_count != $past(qb_count)) |->
         ((qb_count == $past(qb_count) + CNT_W'(1)) ||
          (qb_count == '0 && $past(qb_count) == CNT_W'(QB_WRAP))));    // R2
   AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(rf_pins) & ~rf_pins)) |-> done);                        // R5
endmodule

bind txburst_seq txburst_seq_chk #(
   .CNT_W(CNT_W), .PIN_W(PIN_W), .QB_WRAP(QB_WRAP),
   .WIN_ON(WIN_ON), .WIN_OFF(WIN_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rf_pins(rf_pins), .wr_req(wr_req),
   .wr_busy(wr_busy), .burst_en(burst_en), .done(done), .qb_count(qb_count)
);

// File: tb/txburst_seq_tb.sv
module txburst_seq_tb;
   localparam int CNT_W = 14, QB_DIV = 2, QB_WRAP = 10239, DATA_W = 24, PIN_W = 4;
   localparam int MOD = QB_WRAP + 1;
   localparam int WIN_ON = 'h7A0, WIN_OFF = 'h2700;
   localparam logic [DATA_W-1:0] WARM = 24'h3E_1C42, TXM = 24'h00_0310, TXS = 24'h1A_0045;
   localparam logic [DATA_W-1:0] CHAN_A = 24'h0A_BCDE, CHAN_B = 24'h15_5555;
   localparam logic [PIN_W-1:0] P_VCO = 4'b0001, P_PA = 4'b0011, P_LB = 4'b0111;

   logic clk = 0, rst_n = 0, start = 0, wr_busy = 0;
   logic [DATA_W-1:0] chan_word = '0;
   logic [PIN_W-1:0]  rf_pins;
   logic wr_req, burst_en, done;
   logic [3:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [CNT_W-1:0] qb_count;
   int n_chk = 0, n_err = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   txburst_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_word(chan_word),
      .wr_busy(wr_busy), .rf_pins(rf_pins), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .burst_en(burst_en), .done(done), .qb_count(qb_count)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int dlt(input int a, input int b);
      return (b - a + MOD) % MOD;
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(rf_pins == 0 && !wr_req && !burst_en && !done, "R1 outputs in reset", rf_pins, 0);
      rst_n = 1;
      @(negedge clk);
      chk(qb_count <= 1 && rf_pins == 0 && !burst_en, "R1 after release", qb_count, 0);
   endtask

   task automatic t_counter();
      int c0, n;
      c0 = qb_count;
      while (qb_count == c0) @(negedge clk);
      c0 = qb_count; n = 0;
      while (qb_count == c0) begin @(negedge clk); n++; end
      chk(n == QB_DIV, "R2 tick spacing", n, QB_DIV);
      chk(qb_count == c0 + 1, "R2 increment", qb_count, c0 + 1);
   endtask

   task automatic run_seq(input string tag, input bit stall, input bit poke, input bit wrapped);
      int wa[4], wd[4], wc[4], pc[4];
      logic [PIN_W-1:0] pv[4];
      int nw = 0, np = 0, on_c = -1, off_c = -1, rel_c = -1, hold = 0, ndone = 0, prevc;
      bit poked = 0, busy_bad = 0;
      logic [PIN_W-1:0] prev;
      @(negedge clk); chan_word = CHAN_A; start = 1;
      @(negedge clk); start = 0;
      if (poke) chan_word = CHAN_B;
      prev = rf_pins; prevc = qb_count;
      for (int cyc = 0; cyc < 40000 && ndone == 0; cyc++) begin
         @(negedge clk);
         if (wr_req && wr_busy) busy_bad = 1;
         if (wr_req && nw < 4) begin wa[nw] = wr_addr; wd[nw] = wr_data; wc[nw] = qb_count; end
         if (wr_req) nw++;
         if (rf_pins !== prev) begin
            if (np < 4) begin pv[np] = rf_pins; pc[np] = qb_count; end
            np++; prev = rf_pins;
         end
         if (qb_count != prevc && prevc == QB_WRAP)
            chk(qb_count == 0, {"R2 wrap ", tag}, qb_count, 0);
         prevc = qb_count;
         if (burst_en && on_c < 0) on_c = qb_count;
         if (done) begin
            ndone++; off_c = qb_count;
            chk(!burst_en, {"R8 window closed at done ", tag}, burst_en, 0);
         end
         start = 0;
         if (poke && np == 1 && nw == 0 && !poked) begin start = 1; poked = 1; end
         if (stall && nw == 1 && rel_c < 0) begin
            if (hold < 400) begin wr_busy = 1; hold++; end
            else begin wr_busy = 0; rel_c = qb_count; end
         end
      end
      start = 0; wr_busy = 0;
      chk(ndone == 1 && nw == 4 && np == 4, {"R3 sequence completed ", tag}, nw * 10 + np, 44);
      if (nw != 4 || np != 4) return;
      chk(pv[0] == P_VCO, {"R3 vco pin ", tag}, pv[0], P_VCO);
      chk(dlt(pc[0], wc[0]) == 21, {"R3 vco settle ", tag}, dlt(pc[0], wc[0]), 21);
      chk(wa[0] == 2 && wd[0] == WARM, {"R3 warm-up write ", tag}, wd[0], WARM);
      chk(wa[1] == 1 && wd[1] == CHAN_A, {"R4 R9 channel write ", tag}, wd[1], CHAN_A);
      chk(wa[2] == 2 && wd[2] == TXM, {"R4 tx mode write ", tag}, wd[2], TXM);
      chk(wa[3] == 11 && wd[3] == TXS, {"R4 tx settings write ", tag}, wd[3], TXS);
      if (stall) begin
         chk(wc[1] == (rel_c + 1) % MOD, {"R7 issue after busy ", tag}, wc[1], (rel_c + 1) % MOD);
         chk(!busy_bad, {"R7 no request while busy ", tag}, busy_bad, 0);
      end else
         chk(dlt(wc[0], wc[1]) == 169, {"R4 warm-up wait ", tag}, dlt(wc[0], wc[1]), 169);
      if (wrapped)
         chk(wc[1] < wc[0], {"R6 wait straddles wrap ", tag}, wc[1], wc[0]);
      chk(dlt(wc[1], wc[2]) == 5, {"R4 R7 write gap ", tag}, dlt(wc[1], wc[2]), 5);
      chk(dlt(wc[2], wc[3]) == 5, {"R4 write gap ", tag}, dlt(wc[2], wc[3]), 5);
      chk(pv[1] == P_PA && dlt(wc[3], pc[1]) == 127, {"R5 pa pin ", tag}, dlt(wc[3], pc[1]), 127);
      chk(pv[2] == P_LB && dlt(pc[1], pc[2]) == 12, {"R5 lb pin ", tag}, dlt(pc[1], pc[2]), 12);
      chk(pv[3] == 0 && pc[3] == off_c, {"R5 pins clear at done ", tag}, pv[3], 0);
      chk(on_c == WIN_ON, {"R8 window on ", tag}, on_c, WIN_ON);
      chk(off_c == WIN_OFF, {"R8 window off ", tag}, off_c, WIN_OFF);
      hold = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rf_pins != 0 || wr_req || burst_en || done) hold++;
      end
      chk(hold == 0, {"R9 idle after done ", tag}, hold, 0);
   endtask

   task automatic t_nominal();
      run_seq("nominal", 0, 0, 0);
   endtask

   task automatic t_wrap_poke();
      while (qb_count != QB_WRAP - 40) @(negedge clk);
      run_seq("wrap+poke", 0, 1, 1);   // R6 R9
   endtask

   task automatic t_stall();
      run_seq("stall", 1, 0, 0);       // R7
   endtask

   initial begin
      t_reset();
      t_counter();
      t_nominal();
      t_wrap_poke();
      t_stall();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule